// File: doc/BRIEF.md
# Set-associative data translation cache

This block caches page-directory and page-table entries for data accesses so that most virtual addresses turn into physical addresses without a table walk. Its storage has sets of ways. Each way holds four things: a valid bit, a kind flag marking the payload as a directory entry or a table entry, a tag, and a 32-bit payload. A translation lookup takes a 32-bit virtual address. One cycle later it reports hit or miss and, on a hit, the physical address.

A page walker uses the block in two ways. It asks a second port whether the directory entry for an address is already cached. After reading an entry from memory, it installs that entry through the fill port. A fill goes to a way holding the same key if there is one. Otherwise it takes the lowest free way. When the set is full, a per-set rotating pointer picks the way to evict. A task-switch flush drops every entry except those whose payload marks them global. A full flush drops everything.

Top module: `tlb_pd_cache`

## Requirements
- R1: After reset every entry is invalid, every rotating pointer points at way 0, and all of lk_done, lk_hit, lk_paddr, dq_done, dq_hit and dq_entry are 0.
- R2: Table entries are keyed by set = vaddr[15:12] and tag = vaddr[31:16]. lk_done is high exactly in the cycle after a cycle with lk_valid high, and lk_hit is never high without lk_done.
- R3: A lookup hits when a valid way in its set has kind flag 0 and a matching tag. lk_paddr is then {payload[31:12], vaddr[11:0]}. On a miss, or with no lookup, lk_paddr is 0.
- R4: An entry with kind flag 1 never satisfies a translation lookup, even when its set and tag equal the lookup's.
- R5: Directory entries are keyed by set = vaddr[25:22] and tag = vaddr[31:26] zero-extended to 16 bits. A query raises dq_done one cycle later. dq_hit and dq_entry (the payload) reflect only valid ways with kind flag 1, and dq_entry is 0 on a miss.
- R6: A fill with fill_pd selecting the kind writes valid, kind, tag and payload under that kind's key. If a valid way with the same kind and tag is already in the set, that way is overwritten and no other way changes.
- R7: A fill with no matching way uses the lowest-numbered invalid way. If the set is full, it uses the way named by the set's rotating pointer, and the pointer then advances by one, wrapping to way 0. The pointer changes in no other case.
- R8: flush_task invalidates every entry whose payload bit 8 (the global bit) is 0 and keeps those with bit 8 set.
- R9: flush_all invalidates every entry. Any flush in a cycle takes precedence over a fill in that cycle, and the fill is dropped.
- R10: A lookup or query in the same cycle as a fill or flush sees the contents from before that fill or flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Translation lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit a table entry |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| dq_valid | input | 1 | Directory-entry query request |
| dq_vaddr | input | 32 | Virtual address whose directory entry is wanted |
| dq_done | output | 1 | Query result valid |
| dq_hit | output | 1 | Query found a cached directory entry |
| dq_entry | output | 32 | Cached directory payload, 0 on miss |
| fill_valid | input | 1 | Install an entry |
| fill_pd | input | 1 | Kind of filled entry: 1 directory, 0 table |
| fill_vaddr | input | 32 | Virtual address that keys the filled entry |
| fill_entry | input | 32 | Payload to install |
| flush_task | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
Lookup and query results are due one clock edge after the request. Fills and flushes change what a request sees starting with requests made in the following cycle. The bench drives every input on the falling edge. Before applying that cycle's fill or flush to its reference model, it computes the expected lookup and query results from the model, then compares them at the next falling edge. Because of this ordering, the comparison made on every clock also checks the same-cycle rule of R10, the precedence rule of R9, and the eviction order of R7.

// File: rtl/tlb_pd_cache.sv
module tlb_pd_cache #(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int GLOBAL_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  output logic        lk_done,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  input  logic        dq_valid,
  input  logic [31:0] dq_vaddr,
  output logic        dq_done,
  output logic        dq_hit,
  output logic [31:0] dq_entry,
  input  logic        fill_valid,
  input  logic        fill_pd,
  input  logic [31:0] fill_vaddr,
  input  logic [31:0] fill_entry,
  input  logic        flush_task,
  input  logic        flush_all
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = 20 - IDX_W;
  localparam int DTAG_W = 10 - IDX_W;

  logic [WAYS-1:0]  ent_v   [SETS];
  logic [WAYS-1:0]  ent_pd  [SETS];
  logic [TAG_W-1:0] ent_tag [SETS][WAYS];
  logic [31:0]      ent_dat [SETS][WAYS];
  logic [WAY_W-1:0] rr      [SETS];

  logic [IDX_W-1:0] lk_set, dq_set, fl_set;
  logic [TAG_W-1:0] lk_tag, dq_tag, fl_tag;

  assign lk_set = lk_vaddr[12 +: IDX_W];
  assign lk_tag = lk_vaddr[31 -: TAG_W];
  assign dq_set = dq_vaddr[22 +: IDX_W];
  assign dq_tag = TAG_W'(dq_vaddr[31 -: DTAG_W]);
  assign fl_set = fill_pd ? fill_vaddr[22 +: IDX_W] : fill_vaddr[12 +: IDX_W];
  assign fl_tag = fill_pd ? TAG_W'(fill_vaddr[31 -: DTAG_W]) : fill_vaddr[31 -: TAG_W];

  logic        lk_hit_c, dq_hit_c;
  logic [31:0] lk_dat_c, dq_dat_c;

  always_comb begin
    lk_hit_c = 1'b0;
    lk_dat_c = '0;
    dq_hit_c = 1'b0;
    dq_dat_c = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ent_v[lk_set][w] && !ent_pd[lk_set][w] && ent_tag[lk_set][w] == lk_tag) begin
        lk_hit_c = 1'b1;
        lk_dat_c = ent_dat[lk_set][w];
      end
      if (ent_v[dq_set][w] && ent_pd[dq_set][w] && ent_tag[dq_set][w] == dq_tag) begin
        dq_hit_c = 1'b1;
        dq_dat_c = ent_dat[dq_set][w];
      end
    end
  end

  logic             match_f, inv_f, use_rr;
  logic [WAY_W-1:0] match_w, inv_w, fl_way;

  always_comb begin
    match_f = 1'b0;
    match_w = '0;
    inv_f   = 1'b0;
    inv_w   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!match_f && ent_v[fl_set][w] && ent_pd[fl_set][w] == fill_pd &&
          ent_tag[fl_set][w] == fl_tag) begin
        match_f = 1'b1;
        match_w = WAY_W'(w);
      end
      if (!inv_f && !ent_v[fl_set][w]) begin
        inv_f = 1'b1;
        inv_w = WAY_W'(w);
      end
    end
  end

  assign use_rr = !match_f && !inv_f;
  assign fl_way = match_f ? match_w : (inv_f ? inv_w : rr[fl_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_paddr <= '0;
      dq_done  <= 1'b0;
      dq_hit   <= 1'b0;
      dq_entry <= '0;
      for (int s = 0; s < SETS; s++) begin
        ent_v[s] <= '0;
        rr[s]    <= '0;
      end
    end else begin
      lk_done  <= lk_valid;
      lk_hit   <= lk_valid && lk_hit_c;
      lk_paddr <= (lk_valid && lk_hit_c) ? {lk_dat_c[31:12], lk_vaddr[11:0]} : 32'd0;
      dq_done  <= dq_valid;
      dq_hit   <= dq_valid && dq_hit_c;
      dq_entry <= (dq_valid && dq_hit_c) ? dq_dat_c : 32'd0;
      if (flush_all) begin
        for (int s = 0; s < SETS; s++) ent_v[s] <= '0;
      end else if (flush_task) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!ent_dat[s][w][GLOBAL_BIT]) ent_v[s][w] <= 1'b0;
      end else if (fill_valid) begin
        ent_v[fl_set][fl_way]   <= 1'b1;
        ent_pd[fl_set][fl_way]  <= fill_pd;
        ent_tag[fl_set][fl_way] <= fl_tag;
        ent_dat[fl_set][fl_way] <= fill_entry;
        if (use_rr)
          rr[fl_set] <= (rr[fl_set] == WAY_W'(WAYS - 1)) ? '0 : rr[fl_set] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_pd_cache_chk.sv
module tlb_pd_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic        lk_done,
  input logic        lk_hit,
  input logic [31:0] lk_paddr,
  input logic        dq_valid,
  input logic        dq_done,
  input logic        dq_hit,
  input logic [31:0] dq_entry,
  input logic        flush_all
);
  // R2
  lk_done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> lk_done);
  // R2
  lk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !lk_done);
  // R2
  lk_hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_hit |-> lk_done);
  // R3
  lk_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!lk_hit || lk_paddr[11:0] == $past(lk_vaddr[11:0])));
  // R3
  lk_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !lk_hit |-> lk_paddr == 32'd0);
  // R5
  dq_done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_valid |=> dq_done);
  // R5
  dq_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !dq_hit |-> dq_entry == 32'd0);
  // R9
  flush_lk_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_all ##1 lk_valid |=> !lk_hit);
  // R9
  flush_dq_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_all ##1 dq_valid |=> !dq_hit);
endmodule

bind tlb_pd_cache tlb_pd_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .dq_valid(dq_valid), .dq_done(dq_done), .dq_hit(dq_hit), .dq_entry(dq_entry),
  .flush_all(flush_all)
);

// File: tb/tlb_pd_cache_tb.sv
module tlb_pd_cache_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, dq_valid = 0, fill_valid = 0, fill_pd = 0, flush_task = 0, flush_all = 0;
  logic [31:0] lk_vaddr = 0, dq_vaddr = 0, fill_vaddr = 0, fill_entry = 0;
  logic lk_done, lk_hit, dq_done, dq_hit;
  logic [31:0] lk_paddr, dq_entry;

  tlb_pd_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .dq_valid(dq_valid), .dq_vaddr(dq_vaddr), .dq_done(dq_done), .dq_hit(dq_hit),
    .dq_entry(dq_entry), .fill_valid(fill_valid), .fill_pd(fill_pd),
    .fill_vaddr(fill_vaddr), .fill_entry(fill_entry),
    .flush_task(flush_task), .flush_all(flush_all)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  string cur_req = "R1";

  // reference model: flat list of cached entries per set
  bit          m_v   [16][4];
  bit          m_pd  [16][4];
  int unsigned m_tag [16][4];
  logic [31:0] m_dat [16][4];
  int          m_ptr [16];

  function automatic int key_set(logic [31:0] va, bit pd);
    return pd ? int'(va[25:22]) : int'(va[15:12]);
  endfunction
  function automatic int unsigned key_tag(logic [31:0] va, bit pd);
    return pd ? int'(va[31:26]) : int'(va[31:16]);
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    logic e_lkd, e_lkh, e_dqd, e_dqh;
    logic [31:0] e_lkp, e_dqe;
    int s;
    e_lkd = lk_valid; e_lkh = 0; e_lkp = 0;
    e_dqd = dq_valid; e_dqh = 0; e_dqe = 0;
    s = key_set(lk_vaddr, 0);
    for (int w = 0; w < 4; w++)
      if (lk_valid && m_v[s][w] && !m_pd[s][w] && m_tag[s][w] == key_tag(lk_vaddr, 0)) begin
        e_lkh = 1; e_lkp = {m_dat[s][w][31:12], lk_vaddr[11:0]};
      end
    s = key_set(dq_vaddr, 1);
    for (int w = 0; w < 4; w++)
      if (dq_valid && m_v[s][w] && m_pd[s][w] && m_tag[s][w] == key_tag(dq_vaddr, 1)) begin
        e_dqh = 1; e_dqe = m_dat[s][w];
      end
    if (flush_all) begin
      for (int a = 0; a < 16; a++) for (int w = 0; w < 4; w++) m_v[a][w] = 0;
    end else if (flush_task) begin
      for (int a = 0; a < 16; a++) for (int w = 0; w < 4; w++)
        if (!m_dat[a][w][8]) m_v[a][w] = 0;
    end else if (fill_valid) begin
      int way;
      way = -1;
      s = key_set(fill_vaddr, fill_pd);
      for (int w = 0; w < 4; w++)
        if (way < 0 && m_v[s][w] && m_pd[s][w] == fill_pd && m_tag[s][w] == key_tag(fill_vaddr, fill_pd)) way = w;
      for (int w = 0; w < 4; w++)
        if (way < 0 && !m_v[s][w]) way = w;
      if (way < 0) begin
        way = m_ptr[s];
        m_ptr[s] = (m_ptr[s] + 1) % 4;
      end
      m_v[s][way] = 1; m_pd[s][way] = fill_pd;
      m_tag[s][way] = key_tag(fill_vaddr, fill_pd); m_dat[s][way] = fill_entry;
    end
    @(posedge clk);
    @(negedge clk);
    check({lk_done, lk_hit} == {e_lkd, e_lkh}, "lookup flags", {30'd0, lk_done, lk_hit}, {30'd0, e_lkd, e_lkh});
    check(lk_paddr == e_lkp, "lookup paddr", lk_paddr, e_lkp);
    check({dq_done, dq_hit} == {e_dqd, e_dqh} && dq_entry == e_dqe, "query", dq_entry, e_dqe);
    lk_valid = 0; dq_valid = 0; fill_valid = 0; flush_task = 0; flush_all = 0;
  endtask

  task automatic fill(bit pd, logic [31:0] va, logic [31:0] ent);
    fill_valid = 1; fill_pd = pd; fill_vaddr = va; fill_entry = ent; step();
  endtask
  task automatic look(logic [31:0] va);
    lk_valid = 1; lk_vaddr = va; step();
  endtask
  task automatic query(logic [31:0] va);
    dq_valid = 1; dq_vaddr = va; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) begin
      m_ptr[a] = 0;
      for (int w = 0; w < 4; w++) begin m_v[a][w] = 0; m_pd[a][w] = 0; m_tag[a][w] = 0; m_dat[a][w] = 0; end
    end
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check({lk_done, lk_hit, dq_done, dq_hit} == 4'b0 && lk_paddr == 0 && dq_entry == 0,
          "reset outputs", lk_paddr, 32'd0);
    rst_n = 1;
    look(32'h1234_5678);

    cur_req = "R3";
    fill(0, 32'h1234_5000, 32'hABCD_E123);
    look(32'h1234_5ABC);
    cur_req = "R2";
    look(32'h1235_5ABC);
    look(32'h1234_6ABC);
    step();

    cur_req = "R5";
    fill(1, 32'h0C40_0000, 32'h5555_6007);
    query(32'h0C7F_F123);
    query(32'h1040_0000);
    cur_req = "R4";
    look(32'h0003_1123);

    cur_req = "R10";
    fill_valid = 1; fill_pd = 0; fill_vaddr = 32'h7777_9000; fill_entry = 32'h0000_1000;
    lk_valid = 1; lk_vaddr = 32'h7777_9010; step();
    look(32'h7777_9010);

    cur_req = "R6";
    fill(0, 32'h7777_9000, 32'h0000_2000);
    look(32'h7777_9010);

    cur_req = "R7";
    for (int i = 1; i <= 6; i++) fill(0, {16'(i), 4'h2, 12'h000}, {20'(i * 3), 12'h000});
    for (int i = 1; i <= 6; i++) look({16'(i), 4'h2, 12'h044});

    cur_req = "R8";
    fill(0, 32'h4444_3000, 32'h0101_0100);
    fill(0, 32'h4445_3000, 32'h0202_0000);
    flush_task = 1; lk_valid = 1; lk_vaddr = 32'h4445_3000; step();
    look(32'h4444_3000);
    look(32'h4445_3000);
    look(32'h1234_5000);
    cur_req = "R7";
    fill(0, 32'h4446_3000, 32'h0303_0000);
    look(32'h4446_3000);

    cur_req = "R9";
    flush_all = 1; fill_valid = 1; fill_pd = 0; fill_vaddr = 32'h5151_8000; fill_entry = 32'h0909_0000;
    step();
    look(32'h5151_8000);
    look(32'h4444_3000);
    query(32'h0C40_0000);
    flush_task = 1; fill_valid = 1; fill_pd = 1; fill_vaddr = 32'h0C40_0000; fill_entry = 32'h0000_0100;
    step();
    query(32'h0C40_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule